// File: doc/BRIEF.md
# Page Write Buffer and Program Sequencer

This block sits between a two-wire slave protocol engine and a non-volatile memory array. While a write transaction is open it gathers the data bytes the engine hands over into a small register page. It tracks which page slots hold fresh data. When the engine reports the bus stop condition, the block runs a self-timed program cycle. That cycle pushes the gathered bytes into the array one at a time, and each byte takes one fixed time unit.

The page is 8 bytes (`PAGE_BYTES = 8`) or 2 bytes (`PAGE_BYTES = 2`). The two sizes differ when the master sends more bytes than fit. The 8-byte page advances only the low address bits, so extra bytes wrap over the earliest slots. The 2-byte page refuses the third byte and abandons the whole write. While programming, the block holds `busy` high. The engine uses that flag to withhold acknowledges, and every strobe the block receives during that time is ignored. The length of one time unit is `UNIT_CYCLES` system clocks.

The controller has four states:
- **IDLE**: no transaction is open. An open strobe moves it to COLLECT.
- **COLLECT**: bytes are accepted. A stop moves it to PROGRAM if at least one byte is held, or to IDLE if none is. A new open stays in COLLECT and restarts the page. On the 2-byte page, an overflow byte moves it to ABORTED.
- **ABORTED**: the page has been discarded. A stop moves it to IDLE and an open moves it to COLLECT.
- **PROGRAM**: bytes are written to the array. After the unit of the last byte it returns to IDLE.

Strobe priority is stop, then open, then byte.

Top module: `pgw_sequencer`

## Requirements
- R1: After reset, `busy`, `byte_ack`, `seq_abort` and `arr_we` are all low.
- R2: A byte strobe in COLLECT that is accepted gives `byte_ack` high for one cycle, in the cycle after the strobe. A byte strobe while no transaction is open gets no acknowledge.
- R3: A stop in COLLECT with N held bytes raises `busy` in the next cycle. `busy` then stays high for exactly N × `UNIT_CYCLES` cycles.
- R4: During PROGRAM, `arr_we` pulses once per held byte, in the last cycle of that byte's unit (cycle (k+1)×`UNIT_CYCLES`−1 of busy, counting from 0). Byte k goes to address {upper bits of the opening address, (low bits + k) mod `PAGE_BYTES`}. Its data is the last byte received for that slot.
- R5: On the 8-byte page, only the low 3 address bits advance and they wrap inside the page. The upper 6 bits of the 9-bit address stay fixed. A ninth byte overwrites the slot of the first byte, and 8 bytes are programmed.
- R6: On the 2-byte page, a third byte gets no acknowledge. `seq_abort` rises in the next cycle and stays high until the next open or stop. The following stop starts no program cycle.
- R7: A stop with no held byte starts no program cycle, and `busy` stays low.
- R8: While `busy` is high, open, byte and stop strobes are ignored. No acknowledge is given, and after the cycle ends the block is in IDLE.
- R9: An open strobe during COLLECT discards the bytes gathered so far and restarts the page at the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| open_stb | input | 1 | Write transaction opened, start address valid |
| open_addr | input | ADDR_W | Start address of the write (9 bits by default) |
| byte_stb | input | 1 | One received data byte is valid |
| byte_data | input | DATA_W | Received data byte |
| stop_stb | input | 1 | Bus stop condition seen |
| busy | output | 1 | Program cycle running |
| byte_ack | output | 1 | Previous cycle's byte was accepted |
| seq_abort | output | 1 | Current write sequence has been aborted |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |

## Verification
The assertions assume the following about the inputs:
- Every strobe is a single-cycle pulse.
- A byte strobe is never raised in the same cycle as a stop or an open. If it were, the priority order would drop it, and the acknowledge and counting properties would be unexercised in that case.
- Each byte strobe precedes its stop by at least one cycle.

The directed tasks drive every strobe on the falling clock edge for exactly one cycle, and they never overlap two strobes. The two page variants are run side by side, so the wrap and abort rules are both exercised under the same stimulus timing.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_ABORTED = 2'd2,
        ST_PROGRAM = 2'd3
    } pgw_state_e;

endpackage

// File: rtl/pgw_page_ram.sv
module pgw_page_ram #(
    parameter int PAGE_BYTES = 8,
    parameter int DATA_W     = 8,
    localparam int PW        = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [PW-1:0]     waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [PW-1:0]     raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [PAGE_BYTES-1:0][DATA_W-1:0] slot_bus;

    for (genvar gi = 0; gi < PAGE_BYTES; gi++) begin : g_slot
        logic [DATA_W-1:0] slot_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (we_i && (waddr_i == PW'(gi))) begin
                slot_q <= wdata_i;
            end
        end

        assign slot_bus[gi] = slot_q;
    end

    assign rdata_o = slot_bus[raddr_i];

endmodule

// File: rtl/pgw_fill_track.sv
module pgw_fill_track #(
    parameter int PAGE_BYTES = 8,
    parameter int ADDR_W     = 9,
    localparam int PW        = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1,
    localparam int CW        = PW + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  open_i,
    input  logic [ADDR_W-1:0]     open_addr_i,
    input  logic                  accept_i,
    input  logic                  drop_i,
    output logic [ADDR_W-1:0]     base_addr_o,
    output logic [PW-1:0]         wr_slot_o,
    output logic [CW-1:0]         fill_cnt_o,
    output logic                  full_o,
    output logic [PAGE_BYTES-1:0] mask_o
);

    logic [ADDR_W-1:0]     base_q;
    logic [PW-1:0]         slot_q;
    logic [CW-1:0]         cnt_q;
    logic [PAGE_BYTES-1:0] mask_q;
    logic                  full;

    assign full = (cnt_q == CW'(PAGE_BYTES));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            slot_q <= '0;
            cnt_q  <= '0;
            mask_q <= '0;
        end else if (open_i) begin
            base_q <= open_addr_i;
            slot_q <= open_addr_i[PW-1:0];
            cnt_q  <= '0;
            mask_q <= '0;
        end else if (drop_i) begin
            cnt_q  <= '0;
            mask_q <= '0;
        end else if (accept_i) begin
            mask_q[slot_q] <= 1'b1;
            slot_q         <= slot_q + 1'b1;
            if (!full) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign base_addr_o = base_q;
    assign wr_slot_o   = slot_q;
    assign fill_cnt_o  = cnt_q;
    assign full_o      = full;
    assign mask_o      = mask_q;

    // R5
    mask_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mask_q) == int'(cnt_q));

    // R5
    count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(PAGE_BYTES));

endmodule

// File: rtl/pgw_unit_timer.sv
module pgw_unit_timer #(
    parameter int UNIT_CYCLES = 100000,
    localparam int TW         = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic unit_done_o
);

    logic [TW-1:0] cnt_q;
    logic          at_end;

    assign at_end = (cnt_q == TW'(UNIT_CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || at_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign unit_done_o = run_i && at_end;

    // R4
    timer_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_i) |-> (cnt_q == '0));

endmodule

// File: rtl/pgw_sequencer.sv
module pgw_sequencer
    import pgw_pkg::*;
#(
    parameter int PAGE_BYTES   = 8,
    parameter int ADDR_W       = 9,
    parameter int DATA_W       = 8,
    parameter int UNIT_CYCLES  = 100000,
    parameter bit WRAP_ON_FULL = (PAGE_BYTES > 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_stb,
    input  logic [ADDR_W-1:0] open_addr,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stop_stb,
    output logic              busy,
    output logic              byte_ack,
    output logic              seq_abort,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata
);

    localparam int PW = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;
    localparam int CW = PW + 1;

    pgw_state_e state_q, state_d;

    logic [ADDR_W-1:0]     base_addr;
    logic [PW-1:0]         wr_slot;
    logic [CW-1:0]         fill_cnt;
    logic                  page_full;
    logic [PAGE_BYTES-1:0] slot_mask;
    logic                  unit_done;
    logic [PW-1:0]         prog_idx_q;
    logic [PW-1:0]         rd_slot;
    logic [DATA_W-1:0]     rd_data;
    logic                  prog_last;
    logic                  ack_q;

    logic collecting;
    logic open_ok;
    logic byte_only;
    logic take_byte;
    logic ovf_byte;

    assign collecting = (state_q == ST_COLLECT);
    assign open_ok    = open_stb && !stop_stb && (state_q != ST_PROGRAM);
    assign byte_only  = byte_stb && !stop_stb && !open_stb && collecting;

    if (WRAP_ON_FULL) begin : g_wrap
        assign take_byte = byte_only;
        assign ovf_byte  = 1'b0;
    end else begin : g_abort
        assign take_byte = byte_only && !page_full;
        assign ovf_byte  = byte_only && page_full;
    end

    pgw_fill_track #(
        .PAGE_BYTES (PAGE_BYTES),
        .ADDR_W     (ADDR_W)
    ) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .open_i      (open_ok),
        .open_addr_i (open_addr),
        .accept_i    (take_byte),
        .drop_i      (ovf_byte),
        .base_addr_o (base_addr),
        .wr_slot_o   (wr_slot),
        .fill_cnt_o  (fill_cnt),
        .full_o      (page_full),
        .mask_o      (slot_mask)
    );

    pgw_page_ram #(
        .PAGE_BYTES (PAGE_BYTES),
        .DATA_W     (DATA_W)
    ) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (take_byte),
        .waddr_i (wr_slot),
        .wdata_i (byte_data),
        .raddr_i (rd_slot),
        .rdata_o (rd_data)
    );

    pgw_unit_timer #(
        .UNIT_CYCLES (UNIT_CYCLES)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (state_q == ST_PROGRAM),
        .unit_done_o (unit_done)
    );

    assign rd_slot   = base_addr[PW-1:0] + prog_idx_q;
    assign prog_last = ((CW'(prog_idx_q) + CW'(1)) == fill_cnt);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (stop_stb)     state_d = ST_IDLE;
                else if (open_stb) state_d = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (stop_stb)      state_d = (fill_cnt != '0) ? ST_PROGRAM : ST_IDLE;
                else if (open_stb) state_d = ST_COLLECT;
                else if (ovf_byte) state_d = ST_ABORTED;
            end
            ST_ABORTED: begin
                if (stop_stb)      state_d = ST_IDLE;
                else if (open_stb) state_d = ST_COLLECT;
            end
            ST_PROGRAM: begin
                if (unit_done && prog_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_idx_q <= '0;
            ack_q      <= 1'b0;
        end else begin
            ack_q <= take_byte;
            if (state_q != ST_PROGRAM) begin
                prog_idx_q <= '0;
            end else if (unit_done) begin
                prog_idx_q <= prog_idx_q + 1'b1;
            end
        end
    end

    always_comb begin
        busy      = (state_q == ST_PROGRAM);
        seq_abort = (state_q == ST_ABORTED);
        byte_ack  = ack_q;
        arr_we    = (state_q == ST_PROGRAM) && unit_done && slot_mask[rd_slot];
        arr_addr  = {base_addr[ADDR_W-1:PW], rd_slot};
        arr_wdata = rd_data;
    end

    // R8
    busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !byte_ack);

    // R2
    ack_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ack |-> $past(byte_stb));

    // R6
    abort_no_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_abort && stop_stb) |=> !busy);

    // R7
    empty_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (collecting && (fill_cnt == '0) && stop_stb) |=> !busy);

    // R3
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(arr_we));

endmodule

// File: tb/pgw_sequencer_tb.sv
module pgw_sequencer_tb;

    localparam int UNIT = 20;
    localparam int AW   = 9;
    localparam int DW   = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic [1:0]    open_stb, byte_stb, stop_stb;
    logic [AW-1:0] open_addr [2];
    logic [DW-1:0] byte_data [2];
    logic [1:0]    busy, ack, abrt, we;
    logic [AW-1:0] waddr [2];
    logic [DW-1:0] wdata [2];

    int total = 0;
    int bad   = 0;
    int bcnt [2];
    int wn   [2];
    logic [AW-1:0] la [2][16];
    logic [DW-1:0] ld [2][16];
    int            lp [2][16];

    pgw_sequencer #(.PAGE_BYTES(8), .UNIT_CYCLES(UNIT)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .open_stb(open_stb[0]), .open_addr(open_addr[0]),
        .byte_stb(byte_stb[0]), .byte_data(byte_data[0]), .stop_stb(stop_stb[0]),
        .busy(busy[0]), .byte_ack(ack[0]), .seq_abort(abrt[0]),
        .arr_we(we[0]), .arr_addr(waddr[0]), .arr_wdata(wdata[0])
    );

    pgw_sequencer #(.PAGE_BYTES(2), .UNIT_CYCLES(UNIT)) u_dut_small (
        .clk(clk), .rst_n(rst_n),
        .open_stb(open_stb[1]), .open_addr(open_addr[1]),
        .byte_stb(byte_stb[1]), .byte_data(byte_data[1]), .stop_stb(stop_stb[1]),
        .busy(busy[1]), .byte_ack(ack[1]), .seq_abort(abrt[1]),
        .arr_we(we[1]), .arr_addr(waddr[1]), .arr_wdata(wdata[1])
    );

    always @(negedge clk) begin
        for (int d = 0; d < 2; d++) begin
            if (we[d] && wn[d] < 16) begin
                la[d][wn[d]] = waddr[d];
                ld[d][wn[d]] = wdata[d];
                lp[d][wn[d]] = bcnt[d];
                wn[d] = wn[d] + 1;
            end
            if (busy[d]) bcnt[d] = bcnt[d] + 1;
        end
    end

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clr_mon(int d);
        bcnt[d] = 0;
        wn[d]   = 0;
    endtask

    task automatic do_open(int d, logic [AW-1:0] a);
        @(negedge clk);
        open_addr[d] = a;
        open_stb[d]  = 1'b1;
        @(negedge clk);
        open_stb[d]  = 1'b0;
    endtask

    task automatic do_byte(int d, logic [DW-1:0] v, output logic got);
        @(negedge clk);
        byte_data[d] = v;
        byte_stb[d]  = 1'b1;
        @(negedge clk);
        byte_stb[d]  = 1'b0;
        got = ack[d];
    endtask

    task automatic do_stop(int d);
        @(negedge clk);
        stop_stb[d] = 1'b1;
        @(negedge clk);
        stop_stb[d] = 1'b0;
    endtask

    task automatic wait_idle(int d);
        int g = 0;
        while (busy[d] && g < 5000) begin
            @(negedge clk);
            g++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic chk_write(int d, int k, logic [AW-1:0] a, logic [DW-1:0] v, string tag);
        chk({tag, " addr"}, int'(la[d][k]), int'(a));
        chk({tag, " data"}, int'(ld[d][k]), int'(v));
        chk({tag, " slot time"}, lp[d][k], (k + 1) * UNIT - 1);
    endtask

    task automatic t_reset;
        for (int d = 0; d < 2; d++) begin
            chk("R1 busy after reset", int'(busy[d]), 0);
            chk("R1 ack after reset", int'(ack[d]), 0);
            chk("R1 abort after reset", int'(abrt[d]), 0);
            chk("R1 we after reset", int'(we[d]), 0);
        end
    endtask

    task automatic t_single;
        logic g;
        clr_mon(0);
        do_open(0, 9'h1A5);
        do_byte(0, 8'h3C, g);
        chk("R2 single byte ack", int'(g), 1);
        do_stop(0);
        chk("R3 busy after stop", int'(busy[0]), 1);
        wait_idle(0);
        chk("R3 busy length 1 byte", bcnt[0], UNIT);
        chk("R4 write count 1 byte", wn[0], 1);
        chk_write(0, 0, 9'h1A5, 8'h3C, "R4 single");
    endtask

    task automatic t_wrap3;
        logic g;
        clr_mon(0);
        do_open(0, 9'h0FE);
        do_byte(0, 8'h11, g);
        do_byte(0, 8'h22, g);
        do_byte(0, 8'h33, g);
        chk("R2 third byte ack on big page", int'(g), 1);
        do_stop(0);
        wait_idle(0);
        chk("R3 busy length 3 bytes", bcnt[0], 3 * UNIT);
        chk("R4 write count 3 bytes", wn[0], 3);
        chk_write(0, 0, 9'h0FE, 8'h11, "R4 wrap b0");
        chk_write(0, 1, 9'h0FF, 8'h22, "R4 wrap b1");
        chk_write(0, 2, 9'h0F8, 8'h33, "R5 low bits wrap, upper fixed");
    endtask

    task automatic t_nine;
        logic g;
        int oks = 0;
        clr_mon(0);
        do_open(0, 9'h140);
        for (int i = 0; i < 9; i++) begin
            do_byte(0, 8'(8'hA0 + i), g);
            if (g) oks++;
        end
        chk("R5 nine bytes all acked", oks, 9);
        do_stop(0);
        wait_idle(0);
        chk("R5 busy length full page", bcnt[0], 8 * UNIT);
        chk("R5 write count full page", wn[0], 8);
        chk_write(0, 0, 9'h140, 8'hA8, "R5 ninth overwrites first");
        for (int k = 1; k < 8; k++) begin
            chk_write(0, k, 9'(9'h140 + k), 8'(8'hA0 + k), "R5 page slot");
        end
    endtask

    task automatic t_empty_stop;
        clr_mon(0);
        do_open(0, 9'h033);
        do_stop(0);
        repeat (3) @(negedge clk);
        chk("R7 empty stop busy", bcnt[0], 0);
        chk("R7 empty stop writes", wn[0], 0);
    endtask

    task automatic t_stray_byte;
        logic g;
        clr_mon(0);
        do_byte(0, 8'h5A, g);
        chk("R2 byte without open not acked", int'(g), 0);
        do_stop(0);
        repeat (3) @(negedge clk);
        chk("R2 stray byte no program", bcnt[0], 0);
    endtask

    task automatic t_busy_ignore;
        logic g;
        clr_mon(0);
        do_open(0, 9'h010);
        do_byte(0, 8'h44, g);
        do_stop(0);
        do_open(0, 9'h020);
        do_byte(0, 8'h77, g);
        chk("R8 byte during busy not acked", int'(g), 0);
        do_stop(0);
        wait_idle(0);
        chk("R8 busy length unchanged", bcnt[0], UNIT);
        chk("R8 only one write", wn[0], 1);
        chk_write(0, 0, 9'h010, 8'h44, "R8 original write");
        do_byte(0, 8'h99, g);
        chk("R8 open during busy ignored (idle after)", int'(g), 0);
    endtask

    task automatic t_reopen;
        logic g;
        clr_mon(0);
        do_open(0, 9'h060);
        do_byte(0, 8'hE1, g);
        do_open(0, 9'h0C3);
        do_byte(0, 8'hE2, g);
        do_stop(0);
        wait_idle(0);
        chk("R9 reopen write count", wn[0], 1);
        chk("R9 reopen busy length", bcnt[0], UNIT);
        chk_write(0, 0, 9'h0C3, 8'hE2, "R9 reopen");
    endtask

    task automatic t_small_pair;
        logic g;
        clr_mon(1);
        do_open(1, 9'h033);
        do_byte(1, 8'hA1, g);
        do_byte(1, 8'hB2, g);
        chk("R2 small second byte ack", int'(g), 1);
        do_stop(1);
        wait_idle(1);
        chk("R3 small busy length", bcnt[1], 2 * UNIT);
        chk("R4 small write count", wn[1], 2);
        chk_write(1, 0, 9'h033, 8'hA1, "R4 small b0");
        chk_write(1, 1, 9'h032, 8'hB2, "R4 small b1 wraps");
    endtask

    task automatic t_small_abort;
        logic g;
        clr_mon(1);
        do_open(1, 9'h050);
        do_byte(1, 8'h01, g);
        do_byte(1, 8'h02, g);
        do_byte(1, 8'h03, g);
        chk("R6 third byte not acked", int'(g), 0);
        chk("R6 abort raised", int'(abrt[1]), 1);
        do_stop(1);
        chk("R6 abort cleared by stop", int'(abrt[1]), 0);
        repeat (3) @(negedge clk);
        chk("R6 no program after abort", bcnt[1], 0);
        chk("R6 no writes after abort", wn[1], 0);
    endtask

    initial begin
        int wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 150000) begin
                total++;
                bad++;
                $display("FAIL watchdog expired actual=%0d expected<150000", wd);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        rst_n = 1'b0;
        open_stb = '0; byte_stb = '0; stop_stb = '0;
        for (int d = 0; d < 2; d++) begin
            open_addr[d] = '0;
            byte_data[d] = '0;
            bcnt[d] = 0;
            wn[d] = 0;
        end
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_single();
        t_wrap3();
        t_nine();
        t_empty_stop();
        t_stray_byte();
        t_busy_ignore();
        t_reopen();
        t_small_pair();
        t_small_abort();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule